// File: doc/BRIEF.md
# Tiered Spreading Code Combiner

This block builds the chip stream of a quadrature ranging channel from three nested code tiers. The first tier is a long primary code, the second a 4-chip secondary pattern, and the third a long tertiary code. Each enabled clock produces one output chip, which is the exclusive-OR of the current primary chip, the current secondary chip and the current tertiary chip. The primary and tertiary chips come from outside the block, from code sources such as sequence ROMs or generators. The block tells those sources which chip index it will consume next. The secondary pattern is built inside the block and is picked by a 2-bit select input.

The three position counters are locked together. The secondary index moves only when the primary code wraps. The tertiary index moves only when the secondary code wraps. A synchronous reset or a resync pulse clears all three counters together, so tertiary chip 0 always begins on a frame boundary. The output chip is registered. It comes with strobes that mark the start of a primary period, a secondary period and a tertiary period, and with a frame-start marker.

The external chip sources are expected to register the address they are given. The address outputs therefore show the index that the counters will hold after the coming clock edge. This is one cycle before that chip is consumed.

Top module: `tiered_code_combiner`

## Requirements
- R1: While `rst` or `resync` is high, both address outputs read 0. In the following cycle `chip_vld` and all strobes are low. The next accepted chip uses primary, secondary and tertiary index 0.
- R2: For each cycle with `chip_en` high and neither `rst` nor `resync` high, `chip_vld` is high in the next cycle only. In that cycle `chip_out` equals `pri_chip ^ secondary bit ^ ter_chip`, using the inputs sampled on the enable cycle.
- R3: The secondary pattern for `sec_sel` values 0, 1, 2 and 3 is 4'b1110, 4'b0111, 4'b1011 and 4'b1101. Secondary index k uses pattern bit 3-k, so the most significant bit is sent first.
- R4: The secondary index advances only on an enable that completes a primary period (index PRI_LEN-1). The tertiary index advances only on an enable that completes both the primary and the secondary period.
- R5: `pri_addr` equals the primary index that the next accepted chip will use. This value is shown in the cycle before that chip is consumed. It counts 0 to PRI_LEN-1 and then wraps to 0.
- R6: `ter_addr` follows the same look-ahead rule over 0 to TER_LEN-1.
- R7: `pri_epoch` marks an output chip with primary index 0. `sec_epoch` marks one with primary and secondary index 0. `ter_epoch` marks one with all three indices 0, which recurs every PRI_LEN*4*TER_LEN accepted chips.
- R8: `frame_start` marks only the first output chip after a reset or resync, and it always coincides with `ter_epoch`.
- R9: In a cycle without `chip_en`, the counters and address outputs hold. In the next cycle `chip_vld` and all strobes are low.
- R10: `sec_sel` is sampled on each accepted chip, so a change affects the very next chip without moving any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| resync | input | 1 | Frame-start resync; clears all tier counters |
| chip_en | input | 1 | Chip strobe; one output chip per strobe |
| sec_sel | input | 2 | Secondary pattern select |
| pri_chip | input | 1 | Primary chip for the index shown on `pri_addr` one cycle earlier |
| ter_chip | input | 1 | Tertiary chip for the index shown on `ter_addr` one cycle earlier |
| pri_addr | output | PRI_W | Next primary chip index |
| ter_addr | output | TER_W | Next tertiary chip index |
| chip_out | output | 1 | Combined chip |
| chip_vld | output | 1 | `chip_out` carries a new chip |
| pri_epoch | output | 1 | Chip is first of a primary period |
| sec_epoch | output | 1 | Chip is first of a secondary period |
| ter_epoch | output | 1 | Chip is first of a tertiary period |
| frame_start | output | 1 | First chip after reset or resync |

## Verification
A counter that slips shows up on the address outputs in the same cycle, because those outputs are the counters' next state. It also shows up on the epoch strobes one cycle later. A slip in the secondary or tertiary tier stays hidden until the primary code wraps: up to PRI_LEN enables for the secondary tier, and up to 4*PRI_LEN enables for the tertiary tier. After that, `chip_out` is inverted on every chip whose secondary or tertiary bit differs from the correct one. The bench shortens the tier lengths so that several full tertiary periods, resyncs and pattern changes fit in one run.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   localparam int unsigned SEC_LEN  = 4;
   localparam int unsigned SEC_W    = 2;
   localparam logic [3:0]  SEC_BASE = 4'b1110;

   typedef logic [SEC_LEN-1:0] sec_pat_t;

   // Each selectable pattern is the base pattern rotated right by the select value.
   function automatic sec_pat_t sec_pattern(input logic [SEC_W-1:0] sel);
      sec_pat_t p;
      p = SEC_BASE;
      for (int r = 0; r < int'(sel); r++) p = {p[0], p[SEC_LEN-1:1]};
      return p;
   endfunction
endpackage

// File: rtl/tcc_tier_cnt.sv
module tcc_tier_cnt #(
   parameter int unsigned LEN = 10230,
   parameter int unsigned W   = $clog2(LEN)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] idx,
   output logic [W-1:0] idx_nxt,
   output logic         at_last
);
   localparam logic [W-1:0] LAST = W'(LEN - 1);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("tcc_tier_cnt: LEN must be at least 2");
      end
      if ((1 << W) < LEN) begin : g_bad_w
         $error("tcc_tier_cnt: W too narrow for LEN");
      end
   endgenerate

   assign at_last = (idx == LAST);

   always_comb begin
      if (rst || clr)   idx_nxt = '0;
      else if (adv)     idx_nxt = at_last ? '0 : idx + W'(1);
      else              idx_nxt = idx;
   end

   always_ff @(posedge clk) idx <= idx_nxt;
endmodule

// File: rtl/tcc_sec_sel.sv
module tcc_sec_sel
   import tcc_pkg::*;
(
   input  logic [SEC_W-1:0] sel,
   input  logic [SEC_W-1:0] idx,
   output logic             bit_out
);
   sec_pat_t pats [SEC_LEN];

   generate
      for (genvar g = 0; g < int'(SEC_LEN); g++) begin : g_pat
         assign pats[g] = sec_pattern(SEC_W'(g));
      end
   endgenerate

   // Most significant bit first: index k reads bit (SEC_LEN-1-k).
   always_comb bit_out = pats[sel][SEC_W'(SEC_LEN - 1) - idx];
endmodule

// File: rtl/tiered_code_combiner.sv
module tiered_code_combiner
   import tcc_pkg::*;
#(
   parameter int unsigned PRI_LEN = 10230,
   parameter int unsigned TER_LEN = 1500,
   parameter int unsigned PRI_W   = $clog2(PRI_LEN),
   parameter int unsigned TER_W   = $clog2(TER_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             resync,
   input  logic             chip_en,
   input  logic [1:0]       sec_sel,
   input  logic             pri_chip,
   input  logic             ter_chip,
   output logic [PRI_W-1:0] pri_addr,
   output logic [TER_W-1:0] ter_addr,
   output logic             chip_out,
   output logic             chip_vld,
   output logic             pri_epoch,
   output logic             sec_epoch,
   output logic             ter_epoch,
   output logic             frame_start
);
   generate
      if (SEC_W != 2) begin : g_bad_sec
         $error("tiered_code_combiner: secondary select must be 2 bits");
      end
   endgenerate

   logic [PRI_W-1:0] pri_idx;
   logic [SEC_W-1:0] sec_idx, sec_nxt;
   logic [TER_W-1:0] ter_idx;
   logic             pri_last, sec_last, ter_last;
   logic             sec_adv, ter_adv, sec_bit, first_q;

   assign sec_adv = chip_en && pri_last;
   assign ter_adv = sec_adv && sec_last;

   tcc_tier_cnt #(.LEN(PRI_LEN), .W(PRI_W)) u_pri (
      .clk(clk), .rst(rst), .clr(resync), .adv(chip_en),
      .idx(pri_idx), .idx_nxt(pri_addr), .at_last(pri_last));

   tcc_tier_cnt #(.LEN(SEC_LEN), .W(SEC_W)) u_sec (
      .clk(clk), .rst(rst), .clr(resync), .adv(sec_adv),
      .idx(sec_idx), .idx_nxt(sec_nxt), .at_last(sec_last));

   tcc_tier_cnt #(.LEN(TER_LEN), .W(TER_W)) u_ter (
      .clk(clk), .rst(rst), .clr(resync), .adv(ter_adv),
      .idx(ter_idx), .idx_nxt(ter_addr), .at_last(ter_last));

   tcc_sec_sel u_sel (.sel(sec_sel), .idx(sec_idx), .bit_out(sec_bit));

   logic pri_zero, sec_zero, ter_zero;
   assign pri_zero = (pri_idx == '0);
   assign sec_zero = (sec_idx == '0);
   assign ter_zero = (ter_idx == '0);

   always_ff @(posedge clk) begin
      if (rst || resync) begin
         chip_out    <= 1'b0;
         chip_vld    <= 1'b0;
         pri_epoch   <= 1'b0;
         sec_epoch   <= 1'b0;
         ter_epoch   <= 1'b0;
         frame_start <= 1'b0;
         first_q     <= 1'b1;
      end else if (chip_en) begin
         chip_out    <= pri_chip ^ sec_bit ^ ter_chip;
         chip_vld    <= 1'b1;
         pri_epoch   <= pri_zero;
         sec_epoch   <= pri_zero && sec_zero;
         ter_epoch   <= pri_zero && sec_zero && ter_zero;
         frame_start <= first_q;
         first_q     <= 1'b0;
      end else begin
         chip_vld    <= 1'b0;
         pri_epoch   <= 1'b0;
         sec_epoch   <= 1'b0;
         ter_epoch   <= 1'b0;
         frame_start <= 1'b0;
      end
   end

   logic unused_last;
   assign unused_last = ter_last ^ (|sec_nxt);
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
   parameter int unsigned PRI_LEN = 10230,
   parameter int unsigned TER_LEN = 1500,
   parameter int unsigned PRI_W   = 14,
   parameter int unsigned TER_W   = 11
) (
   input logic             clk,
   input logic             rst,
   input logic             resync,
   input logic             chip_en,
   input logic [PRI_W-1:0] pri_addr,
   input logic [TER_W-1:0] ter_addr,
   input logic             chip_vld,
   input logic             pri_epoch,
   input logic             sec_epoch,
   input logic             ter_epoch,
   input logic             frame_start
);
   localparam logic [31:0] PERIOD = 32'(PRI_LEN * 4 * TER_LEN);

   logic [31:0] since_ter;
   logic        seen_ter;

   always_ff @(posedge clk) begin
      if (rst || resync) begin
         since_ter <= '0;
         seen_ter  <= 1'b0;
      end else if (chip_vld && ter_epoch) begin
         since_ter <= 32'd1;
         seen_ter  <= 1'b1;
      end else if (chip_vld) begin
         since_ter <= since_ter + 32'd1;
      end
   end

   AST_ADDR_CLEAR: assert property (@(posedge clk)
      (rst || resync) |-> (pri_addr == '0 && ter_addr == '0)); // R1
   AST_VLD_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
      chip_vld |-> $past(chip_en)); // R2
   AST_PRI_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
      pri_addr < PRI_W'(PRI_LEN)); // R5
   AST_TER_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
      ter_addr < TER_W'(TER_LEN)); // R6
   AST_EPOCH_NEST: assert property (@(posedge clk) disable iff (rst)
      (ter_epoch |-> sec_epoch) and (sec_epoch |-> pri_epoch) and (pri_epoch |-> chip_vld)); // R7
   AST_TER_PERIOD: assert property (@(posedge clk) disable iff (rst || resync)
      (ter_epoch && seen_ter) |-> (since_ter == PERIOD)); // R7
   AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> ter_epoch); // R8
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!chip_en && !resync) |-> (pri_addr == $past(pri_addr) && ter_addr == $past(ter_addr))); // R9
endmodule

bind tiered_code_combiner tcc_checker #(
   .PRI_LEN(PRI_LEN), .TER_LEN(TER_LEN), .PRI_W(PRI_W), .TER_W(TER_W)
) u_chk (
   .clk(clk), .rst(rst), .resync(resync), .chip_en(chip_en),
   .pri_addr(pri_addr), .ter_addr(ter_addr), .chip_vld(chip_vld),
   .pri_epoch(pri_epoch), .sec_epoch(sec_epoch), .ter_epoch(ter_epoch),
   .frame_start(frame_start));

// File: tb/test_tiered_code_combiner.sv
module test_tiered_code_combiner;
   localparam int P  = 5;
   localparam int T  = 3;
   localparam int PW = $clog2(P);
   localparam int TW = $clog2(T);
   localparam int FULL = P * 4 * T;

   // Expected secondary patterns by select value (R3).
   localparam logic [3:0] EXP_PAT [4] = '{4'b1110, 4'b0111, 4'b1011, 4'b1101};
   // Stimulus table: {chip_en, sec_sel}.
   localparam logic [2:0] STIM [16] = '{
      3'b100, 3'b101, 3'b000, 3'b110, 3'b111, 3'b111, 3'b010, 3'b100,
      3'b101, 3'b110, 3'b001, 3'b111, 3'b100, 3'b110, 3'b011, 3'b101};

   logic clk = 1'b0;
   logic rst = 1'b1, resync = 1'b0, chip_en = 1'b0;
   logic [1:0] sec_sel = 2'd0;
   logic pri_src = 1'b0, ter_src = 1'b0;
   logic [PW-1:0] pri_addr;
   logic [TW-1:0] ter_addr;
   logic chip_out, chip_vld, pri_epoch, sec_epoch, ter_epoch, frame_start;

   always #4 clk = ~clk;

   tiered_code_combiner #(.PRI_LEN(P), .TER_LEN(T)) i_tiered_code_combiner (
      .clk(clk), .rst(rst), .resync(resync), .chip_en(chip_en), .sec_sel(sec_sel),
      .pri_chip(pri_src), .ter_chip(ter_src), .pri_addr(pri_addr), .ter_addr(ter_addr),
      .chip_out(chip_out), .chip_vld(chip_vld), .pri_epoch(pri_epoch),
      .sec_epoch(sec_epoch), .ter_epoch(ter_epoch), .frame_start(frame_start));

   function automatic logic pri_fn(input int i);
      return logic'((i ^ (i >> 2)) & 1);
   endfunction
   function automatic logic ter_fn(input int i);
      return (i == 1);
   endfunction

   // Registered chip sources driven by the address outputs.
   always_ff @(posedge clk) begin
      pri_src <= pri_fn(int'(pri_addr));
      ter_src <= ter_fn(int'(ter_addr));
   end

   int checks = 0, fails = 0;
   int mp = 0, ms = 0, mt = 0;
   bit mfirst = 1'b1;
   int en_cnt = 0;
   bit seen_ter = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   task automatic cyc(input logic en, input logic [1:0] sel, input logic rs, input logic rr);
      int np, ns, nt, op, os, ot;
      logic exp_chip;
      bit fs_exp;
      chip_en = en; sec_sel = sel; resync = rs; rst = rr;
      #1;
      op = mp; os = ms; ot = mt;
      np = mp; ns = ms; nt = mt;
      if (rr || rs) begin
         np = 0; ns = 0; nt = 0;
      end else if (en) begin
         // R4: higher tiers move only on wrap of the tier below
         if (mp == P - 1) begin
            np = 0;
            if (ms == 3) begin
               ns = 0;
               nt = (mt == T - 1) ? 0 : mt + 1;
            end else ns = ms + 1;
         end else np = mp + 1;
      end
      check((rr || rs) ? "R1 pri_addr clear" : "R5 pri_addr", int'(pri_addr), np);
      check((rr || rs) ? "R1 ter_addr clear" : "R6 ter_addr", int'(ter_addr), nt);
      @(posedge clk);
      @(negedge clk);
      if (en && !rs && !rr) begin
         exp_chip = pri_fn(op) ^ EXP_PAT[sel][3 - os] ^ ter_fn(ot);
         fs_exp = mfirst;
         mfirst = 1'b0;
         check("R2 chip_vld", int'(chip_vld), 1);
         check("R2 R3 R4 R10 chip_out", int'(chip_out), int'(exp_chip));
         check("R7 pri_epoch", int'(pri_epoch), int'(op == 0));
         check("R7 sec_epoch", int'(sec_epoch), int'(op == 0 && os == 0));
         check("R7 ter_epoch", int'(ter_epoch), int'(op == 0 && os == 0 && ot == 0));
         check("R8 frame_start", int'(frame_start), int'(fs_exp));
         if (chip_vld && ter_epoch) begin
            if (seen_ter) check("R7 tertiary period", en_cnt, FULL);
            en_cnt = 1; seen_ter = 1'b1;
         end else en_cnt++;
      end else begin
         check((rr || rs) ? "R1 chip_vld low" : "R9 chip_vld low", int'(chip_vld), 0);
         check("R9 strobes low",
               int'({pri_epoch, sec_epoch, ter_epoch, frame_start}), 0);
      end
      if (rr || rs) begin
         mfirst = 1'b1; seen_ter = 1'b0; en_cnt = 0;
      end
      mp = np; ms = ns; mt = nt;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 3; i++) cyc(1'b1, 2'd0, 1'b0, 1'b1);
      // Table walk: mixed enables and pattern selects (R2 R3 R10)
      for (int rep = 0; rep < 12; rep++)
         for (int k = 0; k < 16; k++) cyc(STIM[k][2], STIM[k][1:0], 1'b0, 1'b0);
      // R9: idle with changing select holds everything
      for (int i = 0; i < 6; i++) cyc(1'b0, 2'(i), 1'b0, 1'b0);
      // R8: resync mid-stream while enabled
      cyc(1'b1, 2'd1, 1'b1, 1'b0);
      for (int i = 0; i < 2 * FULL + 3; i++) cyc(1'b1, 2'd2, 1'b0, 1'b0);
      // R10: select changes every chip across a secondary period
      for (int i = 0; i < 24; i++) cyc(1'b1, 2'(i % 4), 1'b0, 1'b0);
      // R1: reset while running, then continuous run over a full period (R7)
      cyc(1'b1, 2'd3, 1'b0, 1'b1);
      for (int i = 0; i < FULL + 5; i++) cyc(1'b1, 2'd3, 1'b0, 1'b0);
      // Resync and enable in back-to-back cycles
      cyc(1'b0, 2'd0, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) cyc(1'b1, 2'd0, 1'b0, 1'b0);
      summary();
      $finish;
   end
endmodule